// File: doc/BRIEF.md
# Peripheral Reference Clock Source Selector and Divider

This block turns one of three fast parent rates into up to two reference clock-enable streams for a peripheral. Everything runs in a single system clock domain. Each parent rate arrives as a stream of single-cycle enable pulses, and each output is a stream of single-cycle enable pulses. No real clock net is switched, so the design stays fully synchronous.

Software writes one control register through a simple write port and can read it back on a read port. The register holds three fields. A 2-bit source code picks the parent. A 6-bit divisor sets how many parent pulses make one output pulse. Two gate bits turn the two outputs on and off. Both outputs are fed by the same divide counter. Source and divisor changes are staged until the counter reaches its terminal count, so a pulse period in progress is never cut short.

A parameter removes the second output for peripherals that need only one.

Top module: `pclk_mdg`

## Requirements
- R1: While reset is asserted and after reset is released, the register reads zero and both outputs stay low until the register is written.
- R2: A write stores reg_wdata bits 13:8 (divisor), 5:4 (source code) and 1:0 (gates). A read returns those bits and zero in every other bit position.
- R3: Source code decode: codes 0 and 1 select parent 0 (src_pulse[0]), code 2 selects parent 1 (src_pulse[1]) and code 3 selects parent 2 (src_pulse[2]). Pulses on parents that are not selected have no effect.
- R4: With divisor N, each output gives one pulse for every N pulses of the selected parent. The output pulse appears in the clock cycle right after the parent pulse that completes the count.
- R5: A divisor of 0 behaves as a divisor of 1, so every selected parent pulse is passed through.
- R6: A new source code or divisor takes effect only at the next terminal count of the divide counter. That terminal count is reached with the previous settings.
- R7: Gate bit 0 enables ref_en[0] and gate bit 1 enables ref_en[1], each on its own. A disabled output stays low. The divide counter keeps running while outputs are gated, so an output that is enabled again stays in phase with the count.
- R8: When HAS_SECOND is 0, ref_en[1] stays low at all times and gate bit 1 has no effect on any output.
- R9: Each output pulse lasts exactly one cycle and follows a cycle in which at least one parent pulse was present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the control register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data: the stored fields, all other bits zero |
| src_pulse | input | 3 | Parent rate enable pulses, index 0..2 |
| ref_en | output | 2 | Gated, divided reference enable pulses |

## Verification
The bench sweeps every source code against a set of divisors that includes 0, 1 and 63, with the three parents pulsing in unrelated patterns. This catches a design that maps code 1 to the wrong parent, or that counts pulses from a parent it did not select. Mid-stream writes check that a new divisor waits for the terminal count; a design that loads it at once would emit a short or an extra pulse. Gate toggling checks that a design which freezes or clears the counter while an output is gated comes back out of phase. A single-output instance checks that gate bit 1 cannot reach a second output that has been configured away.

// File: rtl/pclk_mdg.sv
`timescale 1ns/1ps
module pclk_mdg #(
  parameter int HAS_SECOND = 1,
  parameter int REG_W      = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [2:0]       src_pulse,
  output logic [1:0]       ref_en
);
  localparam int DIV_LO = 8;
  localparam int DIV_W  = 6;
  localparam int SEL_LO = 4;

  logic [1:0]       gate_q;
  logic [1:0]       code_q;
  logic [DIV_W-1:0] div_q;

  logic [1:0]       act_sel;
  logic [DIV_W-1:0] act_div;
  logic [DIV_W-1:0] cnt;
  logic [1:0]       out_q;

  logic             pick;
  logic [DIV_W-1:0] last_cnt;
  logic             term;
  logic             unused_bits;

  function automatic logic [1:0] map_src(input logic [1:0] code);
    case (code)
      2'd2:    map_src = 2'd1;
      2'd3:    map_src = 2'd2;
      default: map_src = 2'd0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= '0;
      code_q <= '0;
      div_q  <= '0;
    end else if (reg_we) begin
      gate_q <= reg_wdata[1:0];
      code_q <= reg_wdata[SEL_LO +: 2];
      div_q  <= reg_wdata[DIV_LO +: DIV_W];
    end
  end

  always_comb begin
    reg_rdata = '0;
    reg_rdata[1:0]            = gate_q;
    reg_rdata[SEL_LO +: 2]    = code_q;
    reg_rdata[DIV_LO +: DIV_W] = div_q;
  end

  assign unused_bits = ^{reg_wdata[REG_W-1:DIV_LO+DIV_W], reg_wdata[SEL_LO-1:2],
                         reg_wdata[DIV_LO-1:SEL_LO+2]};

  always_comb begin
    case (act_sel)
      2'd1:    pick = src_pulse[1];
      2'd2:    pick = src_pulse[2];
      default: pick = src_pulse[0];
    endcase
  end

  assign last_cnt = (act_div == '0) ? '0 : act_div - 1'b1;
  assign term     = pick && (cnt == last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_sel <= '0;
      act_div <= '0;
      cnt     <= '0;
    end else if (pick) begin
      if (term) begin
        cnt     <= '0;
        act_sel <= map_src(code_q);
        act_div <= div_q;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  generate
    if (HAS_SECOND != 0) begin : g_two
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= {term & gate_q[1], term & gate_q[0]};
      end
    end else begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= {1'b0, term & gate_q[0]};
      end
    end
  endgenerate

  assign ref_en = out_q;
endmodule

// File: rtl/pclk_mdg_chk.sv
`timescale 1ns/1ps
module pclk_mdg_chk #(
  parameter int HAS_SECOND = 1,
  parameter int REG_W      = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [REG_W-1:0] reg_rdata,
  input logic [2:0]       src_pulse,
  input logic [1:0]       ref_en
);
  localparam logic [REG_W-1:0] KEEP = REG_W'(32'h0000_3F33);

  p_reset_clear_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (reg_rdata == '0 && ref_en == '0));

  p_read_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~KEEP) == '0);

  p_gate0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_en[0] |-> $past(reg_rdata[0]));

  p_gate1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_en[1] |-> $past(reg_rdata[1]));

  p_absent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_SECOND == 0) |-> !ref_en[1]);

  p_after_parent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_en != '0) |-> $past(src_pulse != '0));
endmodule

bind pclk_mdg pclk_mdg_chk #(.HAS_SECOND(HAS_SECOND), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata),
  .src_pulse(src_pulse), .ref_en(ref_en)
);

// File: tb/pclk_mdg_tb.sv
`timescale 1ns/1ps
module pclk_mdg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [2:0]  pulse = '0;
  logic [31:0] rdata, rdata1;
  logic [1:0]  out, out1;

  always #5 clk = ~clk;

  pclk_mdg #(.HAS_SECOND(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_wdata(wdata),
    .reg_rdata(rdata), .src_pulse(pulse), .ref_en(out));

  pclk_mdg #(.HAS_SECOND(0)) u_dut_one (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_wdata(wdata),
    .reg_rdata(rdata1), .src_pulse(pulse), .ref_en(out1));

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";

  logic [31:0] m_ctrl;
  int m_asel, m_adiv, m_cnt;
  logic [1:0] exp_out;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ctrl = '0; m_asel = 0; m_adiv = 0; m_cnt = 0; exp_out = '0;
  endtask

  task automatic cyc(input logic [2:0] p, input bit w, input logic [31:0] d);
    logic [1:0] nxt;
    int eff;
    @(negedge clk);
    chk(out == exp_out, cur_req, "ref_en", out, exp_out);
    chk(out1 == {1'b0, exp_out[0]}, "R8", "single-output ref_en", out1, {1'b0, exp_out[0]});
    pulse = p; we = w; wdata = d;
    nxt = '0;
    if (p[m_asel]) begin
      eff = (m_adiv == 0) ? 1 : m_adiv;
      if (m_cnt == eff - 1) begin
        nxt    = m_ctrl[1:0];
        m_cnt  = 0;
        m_asel = (m_ctrl[5:4] < 2) ? 0 : int'(m_ctrl[5:4]) - 1;
        m_adiv = int'(m_ctrl[13:8]);
      end else begin
        m_cnt++;
      end
    end
    if (w) m_ctrl = d & 32'h0000_3F33;
    exp_out = nxt;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pulse = '0; we = 1'b0; wdata = '0;
    repeat (2) @(negedge clk);
    chk(out == 2'b00 && rdata == 0, "R1", "in reset", {rdata, out}, 0);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
    chk(out == 2'b00 && rdata == 0, "R1", "after reset", {rdata, out}, 0);
  endtask

  function automatic logic [31:0] cfg(input int div, input int code, input int gates);
    return (32'(div) << 8) | (32'(code) << 4) | 32'(gates);
  endfunction

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int divs[7] = '{0, 1, 2, 3, 5, 7, 63};
    model_reset();
    do_reset();
    cur_req = "R1";
    repeat (5) cyc(3'b111, 0, 0);

    cur_req = "R2";
    cyc(3'b000, 1, 32'hFFFF_FFFF);
    cyc(3'b000, 0, 0);
    chk(rdata == 32'h0000_3F33, "R2", "readback all ones", rdata, 32'h3F33);
    cyc(3'b000, 1, 32'h5A5A_A5A5);
    cyc(3'b000, 0, 0);
    chk(rdata == 32'h0000_2521, "R2", "readback pattern", rdata, 32'h2521);

    for (int code = 0; code < 4; code++) begin
      foreach (divs[k]) begin
        do_reset();
        cur_req = (divs[k] == 0) ? "R5" : ((code < 2) ? "R3 R4 code0/1" : "R3 R4");
        cyc(3'b000, 1, cfg(divs[k], code, 3));
        for (int i = 0; i < 260; i++)
          cyc({(i % 7) < 4, (i % 3) != 1, (i % 2) == 0}, 0, 0);
      end
    end

    do_reset();
    cur_req = "R6";
    cyc(3'b000, 1, cfg(5, 0, 1));
    for (int i = 0; i < 12; i++) cyc(3'b001, 0, 0);
    cyc(3'b001, 1, cfg(2, 3, 1));
    for (int i = 0; i < 20; i++) cyc((i % 2) ? 3'b101 : 3'b001, 0, 0);
    cyc(3'b100, 1, cfg(4, 2, 3));
    for (int i = 0; i < 40; i++) cyc(3'b111, 0, 0);

    do_reset();
    cur_req = "R7";
    cyc(3'b000, 1, cfg(3, 1, 1));
    for (int i = 0; i < 200; i++)
      cyc(3'b001, (i % 5) == 0, cfg(3, 1, (i / 5) % 4));

    for (int d = 1; d <= 8; d++) begin
      for (int g = 1; g <= 2; g++) begin
        int c0, c1, c10;
        do_reset();
        cur_req = "R4 R7";
        cyc(3'b000, 1, cfg(d, 2, g));
        cyc(3'b010, 0, 0);
        cyc(3'b000, 0, 0);
        c0 = 0; c1 = 0; c10 = 0;
        for (int i = 0; i < 5 * d; i++) begin
          cyc(3'b010, 0, 0);
          c0 += out[0]; c1 += out[1]; c10 += out1[1];
          cyc(3'b101, 0, 0);
          c0 += out[0]; c1 += out[1]; c10 += out1[1];
        end
        cyc(3'b000, 0, 0);
        c0 += out[0]; c1 += out[1]; c10 += out1[1];
        chk(c0 == ((g == 1) ? 5 : 0), "R4", "count out0", c0, (g == 1) ? 5 : 0);
        chk(c1 == ((g == 2) ? 5 : 0), "R7", "count out1", c1, (g == 2) ? 5 : 0);
        chk(c10 == 0, "R8", "absent out1 count", c10, 0);
      end
    end

    cur_req = "R9";
    do_reset();
    cyc(3'b000, 1, cfg(1, 0, 3));
    for (int i = 0; i < 30; i++) cyc((i % 4 == 0) ? 3'b001 : 3'b110, 0, 0);
    cyc(3'b000, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule